// File: doc/BRIEF.md
# Two-Group Register Transfer Network

This block holds four data registers split into a low group (slots lo0, lo1) and a high group (slots hi0, hi1), plus one external data input. Data moves only between the groups. Each direction has its own path. A source select picks one register of the sending group or the external input. A two-bit write mask then chooses which registers of the receiving group take that value on the next clock edge.

The low-to-high path and the high-to-low path are independent, so both can be active in the same cycle. Every register is sampled before any register is written, which means a register of one group can be exchanged with a register of the other group in a single cycle. The data width is a parameter with a default of 8 bits. Moves inside a group, arithmetic and memory access are not part of this block.

Top module: `reg_xfer_net`

## Requirements
- R1: `rst` is synchronous and active high. After a clock edge with `rst` high, all four registers read zero. This holds even when transfers are requested in that same cycle.
- R2: Select code 0 picks slot 0 of the sending group and select code 1 picks slot 1. On the next edge, that pre-edge value is written into each receiving register whose mask bit is 1. Mask bit 0 controls slot 0 and mask bit 1 controls slot 1.
- R3: Select code 2 picks `ext_in`, sampled at the edge, as the source value.
- R4: Select code 3 means the path is idle. The receiving group keeps both of its values, whatever the mask says.
- R5: A receiving register whose mask bit is 0 keeps its value.
- R6: With mask 2'b11 and an active select, both registers of the receiving group take the same source value.
- R7: The high-to-low path (`hi_to_lo_sel`, `hi_to_lo_wen`, writing `q_lo0`/`q_lo1`) follows R2 to R6 in the same way as the low-to-high path (`lo_to_hi_sel`, `lo_to_hi_wen`, writing `q_hi0`/`q_hi1`).
- R8: When both paths are active in one cycle, both use the register values from before the edge. A mutual transfer therefore swaps the two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | WIDTH | External data source |
| lo_to_hi_sel | input | 2 | Source select for the low-to-high path (0 = lo0, 1 = lo1, 2 = ext_in, 3 = idle) |
| lo_to_hi_wen | input | 2 | Write mask for hi1 (bit 1) and hi0 (bit 0) |
| hi_to_lo_sel | input | 2 | Source select for the high-to-low path (0 = hi0, 1 = hi1, 2 = ext_in, 3 = idle) |
| hi_to_lo_wen | input | 2 | Write mask for lo1 (bit 1) and lo0 (bit 0) |
| q_lo0 | output | WIDTH | Low group, slot 0 |
| q_lo1 | output | WIDTH | Low group, slot 1 |
| q_hi0 | output | WIDTH | High group, slot 0 |
| q_hi1 | output | WIDTH | High group, slot 1 |

## Verification
The two paths can fire in the same cycle, and each may read a register that the other path is about to overwrite. The bench first preloads all four registers with distinct values through the external input. It then applies every combination of both selects and both masks, 256 in all, each with a fresh external value. After each edge it compares all four registers with a model that updates every register from the pre-edge state. A swap or overwrite that uses a freshly written value therefore shows up as a mismatch.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int GROUP_SIZE = 2;
    localparam int NUM_GROUPS = 2;
    localparam int SEL_W      = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_SLOT0 = 2'd0,
        SRC_SLOT1 = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_IDLE  = 2'd3
    } src_sel_e;

    function automatic logic sel_drives(input src_sel_e sel);
        return sel != SRC_IDLE;
    endfunction

    function automatic logic [GROUP_SIZE-1:0] gate_mask(
        input logic                  active,
        input logic [GROUP_SIZE-1:0] mask
    );
        return mask & {GROUP_SIZE{active}};
    endfunction

endpackage

// File: rtl/xfer_src_mux.sv
module xfer_src_mux
    import xfer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [GROUP_SIZE-1:0][WIDTH-1:0] grp_q,
    input  logic [WIDTH-1:0]                 ext_in,
    input  logic [SEL_W-1:0]                 sel,
    output logic [WIDTH-1:0]                 bus_data,
    output logic                             bus_active
);

    src_sel_e sel_e;

    always_comb begin
        sel_e      = src_sel_e'(sel);
        bus_active = sel_drives(sel_e);
        unique case (sel_e)
            SRC_SLOT0: bus_data = grp_q[0];
            SRC_SLOT1: bus_data = grp_q[1];
            SRC_EXT:   bus_data = ext_in;
            default:   bus_data = '0;
        endcase
    end

endmodule

// File: rtl/xfer_group_regs.sv
module xfer_group_regs
    import xfer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [WIDTH-1:0]                 bus_data,
    input  logic                             bus_active,
    input  logic [GROUP_SIZE-1:0]            wen,
    output logic [GROUP_SIZE-1:0][WIDTH-1:0] grp_q
);

    logic [GROUP_SIZE-1:0] write_now;
    logic [WIDTH-1:0]      slot_r [GROUP_SIZE];

    assign write_now = gate_mask(bus_active, wen);

    for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_r[i] <= '0;
            end else if (write_now[i]) begin
                slot_r[i] <= bus_data;
            end
        end
        assign grp_q[i] = slot_r[i];

        // R5: an unwritten slot holds its value
        a_r5_slot_hold: assert property (@(posedge clk) disable iff (rst)
            !write_now[i] |=> $stable(slot_r[i]));
    end

endmodule

// File: rtl/reg_xfer_net.sv
module reg_xfer_net
    import xfer_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] ext_in,
    input  logic [1:0]       lo_to_hi_sel,
    input  logic [1:0]       lo_to_hi_wen,
    input  logic [1:0]       hi_to_lo_sel,
    input  logic [1:0]       hi_to_lo_wen,
    output logic [WIDTH-1:0] q_lo0,
    output logic [WIDTH-1:0] q_lo1,
    output logic [WIDTH-1:0] q_hi0,
    output logic [WIDTH-1:0] q_hi1
);

    // index 0 = low group, index 1 = high group
    logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0][WIDTH-1:0] group_q;
    logic [NUM_GROUPS-1:0][SEL_W-1:0]                 sel_from;
    logic [NUM_GROUPS-1:0][GROUP_SIZE-1:0]            wen_into;
    logic [NUM_GROUPS-1:0][WIDTH-1:0]                 bus_data;
    logic [NUM_GROUPS-1:0]                            bus_active;

    assign sel_from[0] = lo_to_hi_sel;
    assign sel_from[1] = hi_to_lo_sel;
    assign wen_into[1] = lo_to_hi_wen;
    assign wen_into[0] = hi_to_lo_wen;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        localparam int OTHER = NUM_GROUPS - 1 - g;

        xfer_src_mux #(.WIDTH(WIDTH)) u_mux (
            .grp_q      (group_q[g]),
            .ext_in     (ext_in),
            .sel        (sel_from[g]),
            .bus_data   (bus_data[g]),
            .bus_active (bus_active[g])
        );

        xfer_group_regs #(.WIDTH(WIDTH)) u_regs (
            .clk        (clk),
            .rst        (rst),
            .bus_data   (bus_data[OTHER]),
            .bus_active (bus_active[OTHER]),
            .wen        (wen_into[g]),
            .grp_q      (group_q[g])
        );
    end

    assign q_lo0 = group_q[0][0];
    assign q_lo1 = group_q[0][1];
    assign q_hi0 = group_q[1][0];
    assign q_hi1 = group_q[1][1];

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (q_lo0 == '0 && q_lo1 == '0 && q_hi0 == '0 && q_hi1 == '0));

    a_r2_lo1_to_hi0: assert property (@(posedge clk) disable iff (rst)
        (lo_to_hi_sel == 2'd1 && lo_to_hi_wen[0]) |=> q_hi0 == $past(q_lo1));

    a_r3_ext_to_hi1: assert property (@(posedge clk) disable iff (rst)
        (lo_to_hi_sel == 2'd2 && lo_to_hi_wen[1]) |=> q_hi1 == $past(ext_in));

    a_r4_idle_keeps_hi: assert property (@(posedge clk) disable iff (rst)
        (lo_to_hi_sel == 2'd3) |=> ($stable(q_hi0) && $stable(q_hi1)));

    a_r7_idle_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        (hi_to_lo_sel == 2'd3) |=> ($stable(q_lo0) && $stable(q_lo1)));

    a_r8_swap: assert property (@(posedge clk) disable iff (rst)
        (lo_to_hi_sel == 2'd0 && lo_to_hi_wen == 2'b01 &&
         hi_to_lo_sel == 2'd0 && hi_to_lo_wen == 2'b01)
        |=> (q_hi0 == $past(q_lo0) && q_lo0 == $past(q_hi0)));

endmodule

// File: tb/test_reg_xfer_net.sv
module test_reg_xfer_net;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] ext_in = '0;
    logic [1:0]   lh_sel = 2'd3, lh_wen = 2'b00, hl_sel = 2'd3, hl_wen = 2'b00;
    logic [W-1:0] q_lo0, q_lo1, q_hi0, q_hi1;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    // model: 0=lo0 1=lo1 2=hi0 3=hi1
    logic [W-1:0] mdl [4];

    always #2.5 clk = ~clk;

    reg_xfer_net #(.WIDTH(W)) i_reg_xfer_net (
        .clk(clk), .rst(rst), .ext_in(ext_in),
        .lo_to_hi_sel(lh_sel), .lo_to_hi_wen(lh_wen),
        .hi_to_lo_sel(hl_sel), .hi_to_lo_wen(hl_wen),
        .q_lo0(q_lo0), .q_lo1(q_lo1), .q_hi0(q_hi0), .q_hi1(q_hi1)
    );

    function automatic logic [W-1:0] pick(input logic [1:0] s, input logic [W-1:0] a,
                                          input logic [W-1:0] b, input logic [W-1:0] e);
        return (s == 2'd0) ? a : (s == 2'd1) ? b : e;
    endfunction

    function automatic string tag_for(input logic [1:0] s, input logic m, input logic [1:0] mask,
                                      input bit both, input bit hl);
        if (s == 2'd3) return "R4";
        if (!m)        return "R5";
        if (both)      return "R8";
        if (mask == 2'b11) return "R6";
        if (hl)        return "R7";
        if (s == 2'd2) return "R3";
        return "R2";
    endfunction

    task automatic model_step();
        logic [W-1:0] old [4];
        old = mdl;
        for (int j = 0; j < 2; j++) begin
            if (lh_sel != 2'd3 && lh_wen[j]) mdl[2+j] = pick(lh_sel, old[0], old[1], ext_in);
            if (hl_sel != 2'd3 && hl_wen[j]) mdl[j]   = pick(hl_sel, old[2], old[3], ext_in);
        end
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [1:0] ls, input logic [1:0] lw,
                         input logic [1:0] hs, input logic [1:0] hw, input logic [W-1:0] e);
        @(negedge clk);
        lh_sel = ls; lh_wen = lw; hl_sel = hs; hl_wen = hw; ext_in = e;
        model_step();
        @(negedge clk);
        lh_sel = 2'd3; hl_sel = 2'd3; lh_wen = 2'b00; hl_wen = 2'b00;
    endtask

    task automatic preload(input logic [W-1:0] v0, input logic [W-1:0] v1,
                           input logic [W-1:0] v2, input logic [W-1:0] v3);
        cycle(2'd3, 2'b00, 2'd2, 2'b01, v0);
        cycle(2'd3, 2'b00, 2'd2, 2'b10, v1);
        cycle(2'd2, 2'b01, 2'd3, 2'b00, v2);
        cycle(2'd2, 2'b10, 2'd3, 2'b00, v3);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) mdl[k] = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        check("R1", q_lo0, '0); check("R1", q_lo1, '0);
        check("R1", q_hi0, '0); check("R1", q_hi1, '0);

        for (int c = 0; c < 256; c++) begin
            logic [1:0] ls, lw, hs, hw;
            bit both;
            ls = c[1:0]; lw = c[3:2]; hs = c[5:4]; hw = c[7:6];
            preload(W'(c * 37 + 5), W'(c * 37 + 71), W'(c * 37 + 131), W'(c * 37 + 199));
            both = (ls != 2'd3) && (hs != 2'd3) && (lw != 2'b00) && (hw != 2'b00);
            cycle(ls, lw, hs, hw, W'(c * 53 + 17));
            check(tag_for(hs, hw[0], hw, both, 1'b1), q_lo0, mdl[0]);
            check(tag_for(hs, hw[1], hw, both, 1'b1), q_lo1, mdl[1]);
            check(tag_for(ls, lw[0], lw, both, 1'b0), q_hi0, mdl[2]);
            check(tag_for(ls, lw[1], lw, both, 1'b0), q_hi1, mdl[3]);
        end

        // R1: reset wins over requested transfers
        preload(8'h11, 8'h22, 8'h33, 8'h44);
        @(negedge clk);
        rst = 1'b1; lh_sel = 2'd2; lh_wen = 2'b11; hl_sel = 2'd2; hl_wen = 2'b11; ext_in = 8'hA5;
        @(negedge clk);
        rst = 1'b0; lh_sel = 2'd3; hl_sel = 2'd3; lh_wen = 2'b00; hl_wen = 2'b00;
        check("R1", q_lo0, '0); check("R1", q_lo1, '0);
        check("R1", q_hi0, '0); check("R1", q_hi1, '0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule